// File: doc/BRIEF.md
# Linked-List DMA Descriptor Walker

This block is one DMA channel that moves 32-bit words from memory to a peripheral write port. It does not count against a length register. Instead it follows a chain of nodes held in memory. Software loads the channel address register with the location of the first node and then sets the start bit.

The engine fetches the header word of each node. From the header it takes two fields: how many payload words follow in that node, and where the next node lives. It streams the payload words to the destination port in order. It then follows the next-node pointer until it meets a pointer whose top address bit is set.

The memory side is a single-outstanding request/valid read port. The destination side is a valid/ready write port that can apply backpressure. When the last payload word has been accepted, the engine raises a one-cycle completion pulse and drops its busy flag.

Top module: `ll_dma_walker`

## Requirements
- R1: When a run starts, the first memory read is the header at the address register's value with bits 1:0 cleared. Every memory read address has bits 1:0 equal to zero.
- R2: A header word carries the next-node pointer in bits 23:0 and the payload count in bits 31:24. The payload is read from consecutive word addresses starting at node address + 4. The header word itself never appears on the destination port.
- R3: A node whose count field is zero sends no payload words. The engine goes straight to the pointer check and, if the chain continues, to the next header.
- R4: The chain ends when bit 23 of the next-node pointer is set, whatever the other bits hold (for example 0xFFFFFF, 0x800002 or 0x934567). A pointer with bit 23 clear is always followed, with its bits 1:0 ignored.
- R5: While a payload word is being read, the address register shows the start address of the node that word belongs to. After completion it holds the terminating pointer with bits 1:0 forced to zero.
- R6: A register write with reg_sel=0 loads reg_wdata[23:0] into the address register, including bits 1:0, and the value reads back unchanged.
- R7: When memory answers in the same cycle and the destination is ready, the payload words of a node leave on consecutive clock cycles, one word per clock.
- R8: Memory stalls and destination stalls lose, duplicate or reorder no word. A pending memory request keeps its address until it is answered. A held destination word stays stable until it is accepted.
- R9: A run ends with done high for exactly one cycle. In that cycle busy is already low and no destination word is still pending.
- R10: While busy, a start write (reg_sel=1, reg_wdata[0]=1) and an address write are both ignored.
- R11: After reset, busy, done, mem_req and dst_valid are low and the address register is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 1 | 0 selects the address register, 1 selects control (bit 0 = start) |
| reg_wdata | input | 32 | Register write data |
| addr_reg | output | 24 | Channel address register contents |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle completion pulse |
| mem_req | output | 1 | Memory read request |
| mem_addr | output | 24 | Memory byte address, word aligned |
| mem_valid | input | 1 | Read data valid; completes the pending request |
| mem_rdata | input | 32 | Read data |
| dst_valid | output | 1 | Destination word valid |
| dst_data | output | 32 | Destination word |
| dst_ready | input | 1 | Destination accepts the word this cycle |

## Verification
A wrong count or pointer register shows up at once in the order of memory read addresses. It also changes the number and order of destination words, so the bench compares the complete read-address log and the write log of every run against lists built from the chain it placed in memory. A misdecoded end bit either follows a bogus pointer, which appears as an out-of-range read within a few cycles, or ends the run early with a short word log and the wrong final address. Faults in the stall handling surface as missing or repeated words under random backpressure, or as gaps between words in the unstalled streaming runs.

// File: rtl/ll_dma_pkg.sv
package ll_dma_pkg;
  typedef enum logic [1:0] {
    ST_IDLE,
    ST_HDR,
    ST_PAY,
    ST_LINK
  } walk_st_t;
endpackage

// File: rtl/ll_dma_regs.sv
module ll_dma_regs #(
  parameter int ADDR_W = 24,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              wr_sel,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              upd_en,
  input  logic [ADDR_W-1:0] upd_addr,
  input  logic              fin,
  output logic [ADDR_W-1:0] addr_q,
  output logic              busy_q,
  output logic              go_q,
  output logic              done_q
);
  logic start_ok;
  assign start_ok = wr_en && wr_sel && wr_data[0] && !busy_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      addr_q <= '0;
      busy_q <= 1'b0;
      go_q   <= 1'b0;
      done_q <= 1'b0;
    end else begin
      go_q   <= start_ok;
      done_q <= fin;
      if (wr_en && !wr_sel && !busy_q)
        addr_q <= wr_data[ADDR_W-1:0];
      else if (upd_en)
        addr_q <= upd_addr;
      if (start_ok)
        busy_q <= 1'b1;
      else if (fin)
        busy_q <= 1'b0;
    end
  end

  // R9: completion pulse lasts one cycle and busy is already clear
  a_r9_done_single: assert property (@(posedge clk) disable iff (rst)
    done_q |=> !done_q);
  a_r9_idle_at_done: assert property (@(posedge clk) disable iff (rst)
    done_q |-> !busy_q);
  // R10: start while busy must not relaunch the walker
  a_r10_no_relaunch: assert property (@(posedge clk) disable iff (rst)
    busy_q && !fin |=> busy_q && !go_q);
endmodule

// File: rtl/ll_dma_fifo.sv
module ll_dma_fifo #(
  parameter int DATA_W = 32,
  parameter int DEPTH  = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              push,
  input  logic [DATA_W-1:0] din,
  input  logic              pop_rdy,
  output logic              out_valid,
  output logic [DATA_W-1:0] dout,
  output logic              full,
  output logic              empty
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int OCC_W = $clog2(DEPTH + 1);

  logic [DATA_W-1:0] store [DEPTH];
  logic [PTR_W-1:0]  wp_q, rp_q;
  logic [OCC_W-1:0]  occ_q;
  logic              pop;

  assign empty     = (occ_q == '0);
  assign full      = (occ_q == OCC_W'(DEPTH));
  assign out_valid = !empty;
  assign dout      = store[rp_q];
  assign pop       = out_valid && pop_rdy;

  function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + PTR_W'(1);
  endfunction

  always_ff @(posedge clk) begin
    if (push)
      store[wp_q] <= din;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wp_q  <= '0;
      rp_q  <= '0;
      occ_q <= '0;
    end else begin
      if (push) wp_q <= bump(wp_q);
      if (pop)  rp_q <= bump(rp_q);
      case ({push, pop})
        2'b10:   occ_q <= occ_q + OCC_W'(1);
        2'b01:   occ_q <= occ_q - OCC_W'(1);
        default: occ_q <= occ_q;
      endcase
    end
  end

  // R8: the walker never writes into a full buffer
  a_r8_no_overflow: assert property (@(posedge clk) disable iff (rst)
    push |-> !full);
  // R8: a held destination word is stable until accepted
  a_r8_dst_hold: assert property (@(posedge clk) disable iff (rst)
    out_valid && !pop_rdy |=> out_valid && $stable(dout));
endmodule

// File: rtl/ll_dma_seq.sv
module ll_dma_seq
  import ll_dma_pkg::*;
#(
  parameter int ADDR_W = 24,
  parameter int DATA_W = 32,
  parameter int CNT_W  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              go,
  input  logic [ADDR_W-1:0] start_addr,
  input  logic              mem_valid,
  input  logic [DATA_W-1:0] mem_rdata,
  input  logic              fifo_full,
  input  logic              fifo_empty,
  output logic              mem_req,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              push,
  output logic              upd_en,
  output logic [ADDR_W-1:0] upd_addr,
  output logic              fin
);
  localparam int END_BIT = ADDR_W - 1;
  localparam int CNT_LSB = DATA_W - CNT_W;
  localparam logic [ADDR_W-1:0] WORD = ADDR_W'(4);

  walk_st_t          st_q;
  logic [ADDR_W-1:0] node_q, ptr_q, rd_q;
  logic [CNT_W-1:0]  rem_q, hdr_cnt;
  logic              hs, last_link;

  function automatic logic [ADDR_W-1:0] align(input logic [ADDR_W-1:0] a);
    return {a[ADDR_W-1:2], 2'b00};
  endfunction

  assign hdr_cnt = mem_rdata[CNT_LSB +: CNT_W];

  always_comb begin
    mem_req   = (st_q == ST_HDR) || (st_q == ST_PAY && !fifo_full);
    mem_addr  = (st_q == ST_HDR) ? node_q : rd_q;
    hs        = mem_req && mem_valid;
    push      = (st_q == ST_PAY) && hs;
    last_link = (st_q == ST_LINK) && ptr_q[END_BIT] && fifo_empty;
    fin       = last_link;
    upd_en    = ((st_q == ST_HDR) && hs) || last_link;
    upd_addr  = (st_q == ST_LINK) ? align(ptr_q) : node_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q   <= ST_IDLE;
      node_q <= '0;
      ptr_q  <= '0;
      rd_q   <= '0;
      rem_q  <= '0;
    end else begin
      case (st_q)
        ST_IDLE: if (go) begin
          node_q <= align(start_addr);
          st_q   <= ST_HDR;
        end
        ST_HDR: if (hs) begin
          ptr_q <= mem_rdata[ADDR_W-1:0];
          rem_q <= hdr_cnt;
          rd_q  <= node_q + WORD;
          st_q  <= (hdr_cnt == '0) ? ST_LINK : ST_PAY;
        end
        ST_PAY: if (hs) begin
          rd_q  <= rd_q + WORD;
          rem_q <= rem_q - CNT_W'(1);
          if (rem_q == CNT_W'(1)) st_q <= ST_LINK;
        end
        ST_LINK: begin
          if (ptr_q[END_BIT]) begin
            if (fifo_empty) st_q <= ST_IDLE;
          end else begin
            node_q <= align(ptr_q);
            st_q   <= ST_HDR;
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  // R8: an unanswered request keeps its address
  a_r8_req_hold: assert property (@(posedge clk) disable iff (rst)
    mem_req && !mem_valid |=> mem_req && $stable(mem_addr));
  // R1: all reads are word aligned
  a_r1_aligned: assert property (@(posedge clk) disable iff (rst)
    mem_req |-> mem_addr[1:0] == 2'b00);
  // R3: an empty node goes directly to the pointer check
  a_r3_empty_node: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_HDR) && hs && (hdr_cnt == '0) |=> st_q == ST_LINK);
  // R4: a terminating pointer is never followed
  a_r4_no_follow: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_LINK) && ptr_q[END_BIT] |=> st_q != ST_HDR);
endmodule

// File: rtl/ll_dma_walker.sv
module ll_dma_walker #(
  parameter int ADDR_W     = 24,
  parameter int DATA_W     = 32,
  parameter int CNT_W      = 8,
  parameter int FIFO_DEPTH = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_we,
  input  logic              reg_sel,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [ADDR_W-1:0] addr_reg,
  output logic              busy,
  output logic              done,
  output logic              mem_req,
  output logic [ADDR_W-1:0] mem_addr,
  input  logic              mem_valid,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic              dst_valid,
  output logic [DATA_W-1:0] dst_data,
  input  logic              dst_ready
);
  logic              go, push, upd_en, fin, f_full, f_empty;
  logic [ADDR_W-1:0] upd_addr;

  ll_dma_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regs (
    .clk(clk), .rst(rst),
    .wr_en(reg_we), .wr_sel(reg_sel), .wr_data(reg_wdata),
    .upd_en(upd_en), .upd_addr(upd_addr), .fin(fin),
    .addr_q(addr_reg), .busy_q(busy), .go_q(go), .done_q(done)
  );

  ll_dma_seq #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W)) u_seq (
    .clk(clk), .rst(rst), .go(go), .start_addr(addr_reg),
    .mem_valid(mem_valid), .mem_rdata(mem_rdata),
    .fifo_full(f_full), .fifo_empty(f_empty),
    .mem_req(mem_req), .mem_addr(mem_addr), .push(push),
    .upd_en(upd_en), .upd_addr(upd_addr), .fin(fin)
  );

  ll_dma_fifo #(.DATA_W(DATA_W), .DEPTH(FIFO_DEPTH)) u_fifo (
    .clk(clk), .rst(rst), .push(push), .din(mem_rdata),
    .pop_rdy(dst_ready), .out_valid(dst_valid), .dout(dst_data),
    .full(f_full), .empty(f_empty)
  );

  // R9: nothing is left for the destination when completion is flagged
  a_r9_drained: assert property (@(posedge clk) disable iff (rst)
    done |-> !dst_valid);
endmodule

// File: tb/ll_dma_walker_tb.sv
module ll_dma_walker_tb;
  logic        clk = 1'b0;
  logic        rst;
  logic        reg_we, reg_sel;
  logic [31:0] reg_wdata;
  logic [23:0] addr_reg, mem_addr;
  logic        busy, done, mem_req, mem_valid, dst_valid, dst_ready;
  logic [31:0] mem_rdata, dst_data;

  always #2 clk = ~clk;

  ll_dma_walker u_dut (
    .clk(clk), .rst(rst), .reg_we(reg_we), .reg_sel(reg_sel), .reg_wdata(reg_wdata),
    .addr_reg(addr_reg), .busy(busy), .done(done),
    .mem_req(mem_req), .mem_addr(mem_addr), .mem_valid(mem_valid), .mem_rdata(mem_rdata),
    .dst_valid(dst_valid), .dst_data(dst_data), .dst_ready(dst_ready)
  );

  logic [31:0] mem [256];
  bit          is_hdr [256];
  logic [31:0] exp_rd[$], exp_wr[$], got_rd[$], got_wr[$];
  int          n_chk = 0, n_fail = 0, cyc = 0, done_cnt = 0, prev_cyc = 0;
  bit          mem_stall_en = 0, dst_stall_en = 0, thru_mode = 0, have_prev = 0;
  bit          stall_now = 0;
  logic [23:0] done_addr;
  logic [15:0] lfsr = 16'hACE1;

  assign mem_valid = mem_req && !stall_now;
  assign mem_rdata = mem[mem_addr[9:2]];

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  always @(posedge clk) begin
    #1;
    lfsr      = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    stall_now = mem_stall_en & lfsr[0];
    dst_ready = !dst_stall_en | (lfsr[3] & lfsr[7]);
  end

  always @(negedge clk) begin
    cyc++;
    if (!rst && mem_req && mem_valid) begin
      got_rd.push_back({8'h0, mem_addr});
      if (mem_addr[23:10] != 0) chk(0, "R4 read out of range", {8'h0, mem_addr}, 0);
      else if (!is_hdr[mem_addr[9:2]])
        chk(addr_reg == mem_rdata[23:0], "R5 node address", {8'h0, addr_reg}, {8'h0, mem_rdata[23:0]});
    end
    if (!rst && dst_valid && dst_ready) begin
      got_wr.push_back(dst_data);
      if (thru_mode && have_prev) chk(cyc == prev_cyc + 1, "R7 streaming gap", cyc, prev_cyc + 1);
      prev_cyc  = cyc;
      have_prev = 1;
    end
    if (!rst && done) begin
      done_cnt++;
      done_addr = addr_reg;
      chk(!busy && !dst_valid, "R9 state at done", {busy, dst_valid}, 0);
    end
  end

  task automatic reg_write(input bit sel, input logic [31:0] d);
    @(negedge clk); reg_we = 1; reg_sel = sel; reg_wdata = d;
    @(negedge clk); reg_we = 0; reg_wdata = 0;
  endtask

  task automatic clear_run();
    for (int i = 0; i < 256; i++) begin mem[i] = 32'hDEAD0000 | i; is_hdr[i] = 0; end
    exp_rd.delete(); exp_wr.delete(); got_rd.delete(); got_wr.delete();
  endtask

  task automatic add_node(input logic [23:0] a, input int cnt, input logic [23:0] nxt);
    mem[a[9:2]] = {cnt[7:0], nxt};
    is_hdr[a[9:2]] = 1;
    exp_rd.push_back({8'h0, a});
    for (int i = 0; i < cnt; i++) begin
      logic [23:0] pa;
      pa = a + 24'(4 * (i + 1));
      mem[pa[9:2]] = {i[7:0], a};
      exp_rd.push_back({8'h0, pa});
      exp_wr.push_back({i[7:0], a});
    end
  endtask

  task automatic run_chain(input logic [23:0] start, input logic [23:0] fin_exp,
                           input bit thru, input bit poke, input logic [23:0] poke_exp);
    done_cnt = 0; have_prev = 0; thru_mode = thru;
    reg_write(0, {8'h0, start});
    chk(addr_reg == start, "R6 address readback", {8'h0, addr_reg}, {8'h0, start});
    reg_write(1, 32'h1);
    if (poke) begin
      repeat (3) @(negedge clk);
      reg_write(0, 32'h3F8);
      chk(addr_reg == poke_exp, "R10 address write while busy", {8'h0, addr_reg}, {8'h0, poke_exp});
      reg_write(1, 32'h1);
    end
    for (int i = 0; i < 6000 && done_cnt == 0; i++) @(negedge clk);
    repeat (4) @(negedge clk);
    chk(done_cnt == 1, "R9 done pulse count", done_cnt, 1);
    chk(done_addr == fin_exp, "R5 final address", {8'h0, done_addr}, {8'h0, fin_exp});
    chk(!busy, "R9 busy cleared", busy, 0);
    chk(got_rd.size() == exp_rd.size(), "R2 read count", got_rd.size(), exp_rd.size());
    for (int i = 0; i < exp_rd.size() && i < got_rd.size(); i++)
      if (got_rd[i] != exp_rd[i]) begin
        chk(0, "R1 R2 read address", got_rd[i], exp_rd[i]); break;
      end
    chk(got_wr.size() == exp_wr.size(), "R3 R8 word count", got_wr.size(), exp_wr.size());
    for (int i = 0; i < exp_wr.size() && i < got_wr.size(); i++)
      if (got_wr[i] != exp_wr[i]) begin
        chk(0, "R8 word order", got_wr[i], exp_wr[i]); break;
      end
    thru_mode = 0;
  endtask

  initial begin
    #(4 * 190000);
    chk(0, "watchdog expired", cyc, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [23:0] terms [3];
    terms[0] = 24'hFFFFFF; terms[1] = 24'h800002; terms[2] = 24'h934567;
    rst = 1; reg_we = 0; reg_sel = 0; reg_wdata = 0; dst_ready = 1;
    clear_run();
    repeat (4) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R11 reset state
    chk(!busy && !done && !mem_req && !dst_valid && addr_reg == 0, "R11 reset state",
        {busy, done, mem_req, dst_valid, addr_reg}, 0);

    // R1 R2 R3 R4: three-node chain, misaligned start, empty middle node
    clear_run();
    add_node(24'h100, 3, 24'h203);
    add_node(24'h200, 0, 24'h2C0);
    add_node(24'h2C0, 5, 24'hFFFFFF);
    run_chain(24'h103, 24'hFFFFFC, 0, 0, 0);

    // R7: single node streaming with no stalls
    clear_run();
    add_node(24'h040, 12, 24'h800002);
    run_chain(24'h040, 24'h800000, 1, 0, 0);

    // R10: start and address writes during a long first node
    clear_run();
    add_node(24'h100, 20, 24'h200);
    add_node(24'h200, 2, 24'h934567);
    run_chain(24'h100, 24'h934564, 0, 1, 24'h100);

    // R3 R7: single-node sweep over counts, including the maximum
    for (int c = 0; c <= 7; c++) begin
      int cc;
      cc = (c == 7) ? 255 : c;
      clear_run();
      add_node(24'h000, cc, terms[c % 3]);
      run_chain(24'h000 | 24'(c % 4), {terms[c % 3][23:2], 2'b00}, 1, 0, 0);
    end

    // R4 R8: two-node sweep under memory and destination stalls
    for (int a = 0; a < 4; a++)
      for (int b = 0; b < 4; b++) begin
        mem_stall_en = (a + b) % 2 == 0;
        dst_stall_en = a >= 2 || b == 3;
        clear_run();
        add_node(24'h040, a * 3, 24'h200 | 24'(b));
        add_node(24'h200, b * 2, terms[(a + b) % 3]);
        run_chain(24'h040 | 24'(a), {terms[(a + b) % 3][23:2], 2'b00}, 0, 0, 0);
      end
    mem_stall_en = 0; dst_stall_en = 0;

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule